// File: doc/BRIEF.md
# Message Data Shadow Register

This block places a single 64-bit staging register between a byte-wide host register port and a bank of per-object message data fields. Each field is eight bytes long. The host never reaches the field storage directly. Every byte it reads or writes passes through the staging register. Whole fields move between storage and the staging register only on particular byte accesses. Because of this, a host that walks a field from its top byte down to its bottom byte always sees one consistent message, and it publishes a complete new message in one step.

The object fields sit in the host address space as consecutive eight-byte windows above a base address. A receive path stores incoming message data into the same field bank through a request/grant port. A host commit and a receive store can arrive in the same cycle. In that case the host commit wins and the receive store waits one cycle. Read data is registered and appears one clock after the read strobe, which leaves room for a field load in that same cycle.

Top module: `msg_shadow_buf`

## Requirements
- R1: The result of a read strobe appears on `host_rdata` with `host_rvalid` high exactly one clock after the strobe. `host_rvalid` stays low in the cycle after a write strobe or an idle cycle.
- R2: A read of bytes 0 to 6 first copies the whole field from storage into the staging register when the staging register is empty or holds a different object. The returned byte then comes from the newly copied field.
- R3: A read of bytes 0 to 6 of the object already held returns staging-register content. Receive stores to that object made after the last load are not visible.
- R4: A read of byte 7 always copies the addressed field into the staging register before the byte is returned.
- R5: A write to bytes 1 to 7 changes only the staging register. Field storage keeps its earlier content.
- R6: A write to byte 0 places the byte in the staging register and, at the same clock edge, copies all eight staging bytes into the addressed object's field.
- R7: With base B (default 80h), object n (0 to 15) occupies addresses B+8n to B+8n+7. Byte k of the field sits at B+8n+k. Byte k is bits 8k+7 down to 8k of the 64-bit field.
- R8: A strobe to an address outside the object windows changes nothing. A read there returns 00h with `host_rvalid` high.
- R9: When no host commit occurs in the same cycle, `rx_ready` is high in any cycle where `rx_req` is high, and `rx_data` is stored into field `rx_obj` at that clock edge. `rx_ready` is never high without `rx_req`.
- R10: In a cycle with a host commit (a write to byte 0), `rx_ready` is low and the receive store does not take place in that cycle.
- R11: After reset, `host_rvalid` and `host_rdata` are zero, all fields hold zero, and the staging register holds no object.
- R12: A write to an object the staging register does not hold retargets the register to that object without loading from storage. A later read of bytes 0 to 6 of that object returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read result valid, one clock after a read strobe |
| rx_req | input | 1 | Receive path requests a field store |
| rx_obj | input | 4 | Object targeted by the receive store |
| rx_data | input | 64 | Field content to store |
| rx_ready | output | 1 | Receive store accepted this cycle |

## Verification
The bench places receive stores between a load and the reads that follow it. A design that reloaded on every read would show the new data where the held snapshot is expected, and a design that never reloaded on byte 7 would return stale data. Writes to the upper bytes are followed by a byte-7 read of the same object, which catches any partial write-through into storage. Host commits are issued in the same cycle as a receive request, so a wrong priority shows up either as `rx_ready` high or as a lost or overwritten field. Object-switch reads, retargeting writes, the top and bottom object windows, and out-of-window strobes are also covered, each alongside a long random mix.

// File: rtl/msb_pkg.sv
package msb_pkg;
   localparam int LANES   = 8;
   localparam int LANE_W  = 3;
   localparam int BYTE_W  = 8;
   localparam int FIELD_W = LANES * BYTE_W;
   localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);
   localparam logic [LANE_W-1:0] BOT_LANE = '0;

   typedef logic [BYTE_W-1:0]  byte_t;
   typedef logic [FIELD_W-1:0] field_t;
   typedef logic [LANE_W-1:0]  lane_t;
endpackage

// File: rtl/msb_addr_dec.sv
module msb_addr_dec
   import msb_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'h80,
   parameter int NUM_OBJ   = 16,
   parameter int OBJ_W     = 4
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              rd_acc,
   output logic              wr_acc,
   output logic              rd_any,
   output logic [OBJ_W-1:0]  obj,
   output lane_t             lane
);
   localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE_ADDR);
   localparam logic [ADDR_W:0] SPAN_X = (ADDR_W+1)'(NUM_OBJ * LANES);

   logic [ADDR_W:0] offset;

   always_comb begin
      offset = {1'b0, addr} - BASE_X;
      hit    = ({1'b0, addr} >= BASE_X) && (offset < SPAN_X);
      obj    = offset[OBJ_W+LANE_W-1:LANE_W];
      lane   = offset[LANE_W-1:0];
      rd_acc = sel && !wr && hit;
      wr_acc = sel && wr && hit;
      rd_any = sel && !wr;
   end
endmodule

// File: rtl/msb_obj_ram.sv
module msb_obj_ram
   import msb_pkg::*;
#(
   parameter int NUM_OBJ = 16,
   parameter int OBJ_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OBJ_W-1:0] rd_obj,
   output field_t           rd_field,
   input  logic             cm_we,
   input  logic [OBJ_W-1:0] cm_obj,
   input  field_t           cm_field,
   input  logic             rx_req,
   input  logic [OBJ_W-1:0] rx_obj,
   input  field_t           rx_field,
   output logic             rx_grant
);
   field_t mem [NUM_OBJ];

   // host commit has priority; receive store waits
   assign rx_grant = rx_req && !cm_we;

   for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[i] <= '0;
         end else if (cm_we && (cm_obj == OBJ_W'(i))) begin
            mem[i] <= cm_field;
         end else if (rx_grant && (rx_obj == OBJ_W'(i))) begin
            mem[i] <= rx_field;
         end
      end
   end

   always_comb begin
      rd_field = '0;
      for (int j = 0; j < NUM_OBJ; j++) begin
         if (rd_obj == OBJ_W'(j)) rd_field = mem[j];
      end
   end
endmodule

// File: rtl/msb_shadow.sv
module msb_shadow
   import msb_pkg::*;
#(
   parameter int OBJ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  field_t           load_field,
   input  logic             wr_en,
   input  lane_t            wr_lane,
   input  byte_t            wr_byte,
   input  logic [OBJ_W-1:0] obj,
   output field_t           field,
   output logic [OBJ_W-1:0] held_obj,
   output logic             held_valid
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            field[k*BYTE_W +: BYTE_W] <= '0;
         end else if (load) begin
            field[k*BYTE_W +: BYTE_W] <= load_field[k*BYTE_W +: BYTE_W];
         end else if (wr_en && (wr_lane == LANE_W'(k))) begin
            field[k*BYTE_W +: BYTE_W] <= wr_byte;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_obj   <= '0;
         held_valid <= 1'b0;
      end else if (load || wr_en) begin
         held_obj   <= obj;
         held_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/msg_shadow_buf.sv
module msg_shadow_buf
   import msb_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'h80,
   parameter int NUM_OBJ   = 16,
   parameter int OBJ_W     = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              host_rvalid,
   input  logic              rx_req,
   input  logic [OBJ_W-1:0]  rx_obj,
   input  logic [63:0]       rx_data,
   output logic              rx_ready
);
   if (NUM_OBJ < 1 || OBJ_W + LANE_W > ADDR_W + 1 ||
       BASE_ADDR + NUM_OBJ * LANES > (1 << ADDR_W)) begin : g_bad_cfg
      $error("msg_shadow_buf: object windows do not fit the address space");
   end

   logic             dec_hit, dec_rd, dec_wr, dec_rd_any;
   logic [OBJ_W-1:0] dec_obj;
   lane_t            dec_lane;
   field_t           ram_field, sh_field, commit_field, src_field;
   logic [OBJ_W-1:0] sh_obj;
   logic             sh_valid, need_load, commit;
   byte_t            rd_byte;

   msb_addr_dec #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W)
   ) u_dec (
      .sel(host_sel), .wr(host_wr), .addr(host_addr),
      .hit(dec_hit), .rd_acc(dec_rd), .wr_acc(dec_wr), .rd_any(dec_rd_any),
      .obj(dec_obj), .lane(dec_lane)
   );

   always_comb begin
      need_load    = dec_rd && (!sh_valid || (sh_obj != dec_obj) || (dec_lane == TOP_LANE));
      commit       = dec_wr && (dec_lane == BOT_LANE);
      commit_field = {sh_field[FIELD_W-1:BYTE_W], host_wdata};
      src_field    = need_load ? ram_field : sh_field;
      rd_byte      = src_field[dec_lane*BYTE_W +: BYTE_W];
   end

   msb_obj_ram #(.NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .rd_obj(dec_obj), .rd_field(ram_field),
      .cm_we(commit), .cm_obj(dec_obj), .cm_field(commit_field),
      .rx_req(rx_req), .rx_obj(rx_obj), .rx_field(rx_data),
      .rx_grant(rx_ready)
   );

   msb_shadow #(.OBJ_W(OBJ_W)) u_shadow (
      .clk(clk), .rst_n(rst_n),
      .load(need_load), .load_field(ram_field),
      .wr_en(dec_wr), .wr_lane(dec_lane), .wr_byte(host_wdata),
      .obj(dec_obj),
      .field(sh_field), .held_obj(sh_obj), .held_valid(sh_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
      end else begin
         host_rvalid <= dec_rd_any;
         if (dec_rd_any) host_rdata <= dec_hit ? rd_byte : '0;
      end
   end
endmodule

// File: rtl/msg_shadow_buf_chk.sv
module msg_shadow_buf_chk
   import msb_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  host_sel,
   input logic  host_wr,
   input logic  host_rvalid,
   input logic  dec_rd,
   input lane_t dec_lane,
   input logic  need_load,
   input logic  commit,
   input logic  rx_req,
   input logic  rx_ready
);
   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !host_wr) |=> host_rvalid); // R1
   AST_NO_RVALID_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_sel && !host_wr) |=> !host_rvalid); // R1
   AST_TOP_BYTE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_rd && dec_lane == TOP_LANE) |-> need_load); // R4
   AST_RX_GRANTED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req && !commit) |-> rx_ready); // R9
   AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> rx_req); // R9
   AST_COMMIT_STALLS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !rx_ready); // R10
endmodule

bind msg_shadow_buf msg_shadow_buf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
   .host_rvalid(host_rvalid), .dec_rd(dec_rd), .dec_lane(dec_lane),
   .need_load(need_load), .commit(commit), .rx_req(rx_req), .rx_ready(rx_ready)
);

// File: tb/msg_shadow_buf_test.sv
module msg_shadow_buf_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_wr = 1'b0;
   logic [7:0]  host_addr = '0, host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_rvalid;
   logic        rx_req = 1'b0;
   logic [3:0]  rx_obj = '0;
   logic [63:0] rx_data = '0;
   logic        rx_ready;

   int checks = 0, errors = 0;

   logic [63:0] m_ram [16];
   logic [63:0] m_sh;
   logic [3:0]  m_obj;
   bit          m_valid;
   bit          pend_rv;
   logic [7:0]  pend_data;
   string       pend_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   msg_shadow_buf uut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .rx_req(rx_req), .rx_obj(rx_obj),
      .rx_data(rx_data), .rx_ready(rx_ready)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] lane_of(input logic [63:0] f, input int k);
      return f[k*8 +: 8];
   endfunction

   task automatic step(input bit sel, input bit wr, input logic [7:0] addr,
                       input logic [7:0] wd, input bit rq, input logic [3:0] ro,
                       input logic [63:0] rd, input string tag = "");
      bit in_rng, commit, exp_rdy, load;
      int obj, b;
      @(negedge clk);
      if (pend_rv) begin
         chk("R1", "rvalid after read", 64'(host_rvalid), 64'd1);
         chk(pend_tag, "read data", 64'(host_rdata), 64'(pend_data));
      end else begin
         chk("R1", "rvalid idle", 64'(host_rvalid), 64'd0);
      end
      host_sel = sel; host_wr = wr; host_addr = addr; host_wdata = wd;
      rx_req = rq; rx_obj = ro; rx_data = rd;
      #1;
      in_rng  = (addr >= 8'h80);
      obj     = (int'(addr) - 'h80) >> 3;
      b       = int'(addr[2:0]);
      commit  = sel && wr && in_rng && (b == 0);
      exp_rdy = rq && !commit;
      chk(commit && rq ? "R10" : "R9", "rx_ready", 64'(rx_ready), 64'(exp_rdy));
      pend_rv = sel && !wr;
      if (sel && !wr) begin
         if (!in_rng) begin
            pend_data = 8'h00; pend_tag = "R8";
         end else begin
            load = !m_valid || (int'(m_obj) != obj) || (b == 7);
            pend_tag = (b == 7) ? "R4" : (load ? "R2" : "R3");
            if (load) m_sh = m_ram[obj];
            m_obj = 4'(obj); m_valid = 1;
            pend_data = lane_of(m_sh, b);
         end
         if (tag != "") pend_tag = tag;
      end else if (sel && wr && in_rng) begin
         m_sh[b*8 +: 8] = wd;
         m_obj = 4'(obj); m_valid = 1;
         if (b == 0) m_ram[obj] = m_sh;
      end
      if (exp_rdy) m_ram[ro] = rd;
   endtask

   task automatic rd(input logic [7:0] a, input string tag = "");
      step(1, 0, a, 8'h00, 0, 4'h0, 64'h0, tag);
   endtask
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      step(1, 1, a, d, 0, 4'h0, 64'h0);
   endtask
   task automatic rx(input logic [3:0] o, input logic [63:0] d);
      step(0, 0, 8'h00, 8'h00, 1, o, d);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) m_ram[i] = '0;
      m_sh = '0; m_obj = '0; m_valid = 0; pend_rv = 0; pend_data = '0; pend_tag = "";
      repeat (3) @(negedge clk);
      chk("R11", "rvalid in reset", 64'(host_rvalid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "rvalid after reset", 64'(host_rvalid), 64'd0);
      chk("R11", "rdata after reset", 64'(host_rdata), 64'd0);
      chk("R11", "rx_ready after reset", 64'(rx_ready), 64'd0);
      rd(8'h9B, "R11");                       // object 3 byte 3 of a cleared field

      // receive store, then reload on byte 7, then snapshot kept for lower bytes
      rx(4'd1, 64'h1122334455667788);          // R9
      rd(8'h8F);                               // R4 -> 11
      rx(4'd1, 64'hA0A1A2A3A4A5A6A7);
      rd(8'h8E);                               // R3 -> old 22
      rd(8'h88);                               // R3 -> old 88
      rd(8'h8F);                               // R4 -> new A0
      rd(8'h93);                               // R2 switch to object 2
      rd(8'h8A);                               // R2 back to object 1

      // upper-byte writes stay in the staging register
      for (int k = 7; k >= 1; k--) wr(8'h90 + 8'(k), 8'h50 + 8'(k));
      rd(8'h97, "R5");                         // reload shows field still zero
      rd(8'h91, "R5");

      // full write with commit racing a receive store
      for (int k = 7; k >= 1; k--) wr(8'h90 + 8'(k), 8'hC0 + 8'(k));
      step(1, 1, 8'h90, 8'hC0, 1, 4'd5, 64'h5555AAAA5555AAAA);   // R10 stall
      rx(4'd5, 64'h5555AAAA5555AAAA);          // R9 retry granted
      for (int k = 7; k >= 0; k--) rd(8'h90 + 8'(k), "R6");
      rd(8'hAF, "R9");
      rd(8'hA8, "R9");

      // window edges
      for (int k = 7; k >= 0; k--) wr(8'hF8 + 8'(k), 8'hE0 + 8'(k));
      rd(8'hFF, "R7");
      rd(8'hF8, "R7");
      wr(8'h80, 8'h3C);                        // object 0 commit
      rd(8'h87, "R7");
      rd(8'h80, "R7");

      // outside the windows
      wr(8'h7F, 8'h99);
      wr(8'h00, 8'h77);
      rd(8'h40);                               // R8
      rd(8'h80, "R8");                         // object 0 untouched

      // retarget by write without load
      rx(4'd5, 64'h0102030405060708);
      wr(8'hAB, 8'h6D);
      rd(8'hAB, "R12");
      rd(8'hAA, "R12");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         bit s, w, q;
         logic [7:0] a;
         s = ($urandom_range(0, 9) < 7);
         w = $urandom_range(0, 1) == 1;
         a = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 127))
                                         : 8'($urandom_range(128, 255));
         q = ($urandom_range(0, 9) < 3);
         step(s, w, a, 8'($urandom), q, 4'($urandom_range(0, 15)),
              {$urandom, $urandom});
      end
      step(0, 0, 8'h00, 8'h00, 0, 4'h0, 64'h0);
      step(0, 0, 8'h00, 8'h00, 0, 4'h0, 64'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule